// File: doc/BRIEF.md
# Edge-Triggered Lockout Debouncer

This block cleans up a bouncing one-bit signal such as a switch contact or a slow opto-coupled line. It does not wait for the input to go quiet before it switches. The output follows the first qualifying transition straight away and then ignores the input for a fixed number of clock cycles. The raw input is asynchronous, so it first passes through a flop-chain synchronizer. Transitions are then found by comparing the synchronized value with its value one cycle earlier.

A two-bit phase register steps through four phases: waiting for a rise, holding high, waiting for a fall and holding low. The two holdoff lengths are separate parameters, one for the time after a rise and one for the time after a fall. Both are counted in clock cycles, and a holdoff runs to completion once started. The input may end up in a different level during a holdoff. In that case the block sees the mismatch on the final holdoff cycle and switches at once, so the change is never lost.

Besides the clean level, the block gives a one-cycle strobe for each rise and for each fall. Every port is a plain control or status pin. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure.

Top module: `lockout_debouncer`

## Requirements
- R1: A synchronous reset (`rst` high on a clock edge) clears the synchronizer, the holdoff counter and both strobes, and puts the block in the wait-for-rise phase with `level_out` low.
- R2: In the wait-for-rise phase, a low-to-high change of `noisy_in` that stays stable drives `level_out` high on the third rising clock edge that samples the new value, with the default two-stage synchronizer.
- R3: After a rise, `level_out` stays high for exactly RISE_HOLD clock cycles whatever `noisy_in` does. After a fall, it stays low for exactly FALL_HOLD cycles whatever `noisy_in` does.
- R4: In the wait-for-fall phase, a high-to-low change of `noisy_in` that stays stable drives `level_out` low on the third rising clock edge that samples the new value.
- R5: A holdoff does not restart or stretch when the input changes during it. It always ends RISE_HOLD or FALL_HOLD cycles after the output change that began it.
- R6: On the final cycle of a holdoff, the block compares the synchronized input with `level_out`. If they differ, the output changes on that same edge, the matching strobe fires and the opposite holdoff starts. If they agree, the block enters the matching wait phase.
- R7: `rise_pulse` is high for exactly the one cycle in which `level_out` has just gone from low to high, and `fall_pulse` likewise for a high-to-low change. The two strobes are never high together, and `level_out` never changes without one of them.
- R8: The phase is held in two bits: wait-rise 00, hold-high 01, wait-fall 11, hold-low 10. Bit 0 is the output level. The phases advance in the order wait-rise, hold-high, wait-fall, hold-low. The only shortcut is from one hold straight to the opposite hold, under R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| noisy_in | input | 1 | Raw asynchronous input that may bounce |
| level_out | output | 1 | Debounced level, registered |
| rise_pulse | output | 1 | One-cycle strobe when `level_out` rises |
| fall_pulse | output | 1 | One-cycle strobe when `level_out` falls |

## Verification
The bench drives every 10-bit input pattern in turn, one bit per clock, with a settling gap between patterns. It compares all three outputs on every cycle against an arithmetic model of the phase sequence. This sweep covers glitches that land in the last holdoff cycle, single-cycle spikes, and levels that flip back just as a holdoff expires. A design with an off-by-one holdoff would switch one cycle early or late. A design whose timer restarts on each edge would hold the output too long. A design that keys only on edges would miss a level change hidden by the holdoff and stay wrong indefinitely. Directed sequences pin down the exact synchronizer latency, the hidden-change case at the end of each holdoff, and a reset that arrives while the output is high.

// File: rtl/lockout_debouncer_pkg.sv
package lockout_debouncer_pkg;

  // Gray-ordered phases; bit 0 equals the driven output level.
  typedef enum logic [1:0] {
    PH_WAIT_RISE = 2'b00,
    PH_HOLD_HIGH = 2'b01,
    PH_WAIT_FALL = 2'b11,
    PH_HOLD_LOW  = 2'b10
  } phase_t;

  function automatic logic phase_is_hold(phase_t p);
    return (p == PH_HOLD_HIGH) || (p == PH_HOLD_LOW);
  endfunction

endpackage

// File: rtl/dbn_sync.sv
module dbn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[gi] <= 1'b0;
          else     chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/dbn_edge.sv
module dbn_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic went_up,
  output logic went_down
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (rst) sig_q <= 1'b0;
    else     sig_q <= sig;
  end

  assign went_up   = sig & ~sig_q;
  assign went_down = ~sig & sig_q;

  // R2 R4: an edge reported now means the level moved since last cycle
  edge_move_chk: assert property (@(posedge clk) disable iff (rst)
    (went_up || went_down) |=> (sig_q != $past(sig_q)));
endmodule

// File: rtl/dbn_holdoff.sv
module dbn_holdoff #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          busy,
  output logic          last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign last = (cnt == CW'(1));

  // R3: a started holdoff always has a nonzero length
  load_len_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> (load_val != '0));

  // R5: without a new load the count only goes down by one, never restarts
  no_retrigger_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && busy) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/lockout_debouncer.sv
module lockout_debouncer
  import lockout_debouncer_pkg::*;
#(
  parameter int RISE_HOLD   = 16,
  parameter int FALL_HOLD   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic noisy_in,
  output logic level_out,
  output logic rise_pulse,
  output logic fall_pulse
);
  localparam int MAX_HOLD = (RISE_HOLD > FALL_HOLD) ? RISE_HOLD : FALL_HOLD;
  localparam int CW       = $clog2(MAX_HOLD + 1);

  logic          sig_lvl, sig_up, sig_down;
  logic          hold_busy, hold_last;
  logic          go_up, go_down, hold_load;
  logic [CW-1:0] hold_val;
  phase_t        ph, ph_n;

  dbn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(noisy_in), .sync_out(sig_lvl));

  dbn_edge u_edge (
    .clk(clk), .rst(rst), .sig(sig_lvl),
    .went_up(sig_up), .went_down(sig_down));

  dbn_holdoff #(.CW(CW)) u_hold (
    .clk(clk), .rst(rst), .load(hold_load), .load_val(hold_val),
    .busy(hold_busy), .last(hold_last));

  always_comb begin
    ph_n    = ph;
    go_up   = 1'b0;
    go_down = 1'b0;
    unique case (ph)
      PH_WAIT_RISE: if (sig_up) go_up = 1'b1;
      PH_HOLD_HIGH: if (hold_last) begin
                      if (!sig_lvl) go_down = 1'b1;
                      else          ph_n    = PH_WAIT_FALL;
                    end
      PH_WAIT_FALL: if (sig_down) go_down = 1'b1;
      PH_HOLD_LOW:  if (hold_last) begin
                      if (sig_lvl) go_up = 1'b1;
                      else         ph_n  = PH_WAIT_RISE;
                    end
      default:      ph_n = PH_WAIT_RISE;
    endcase
    if (go_up)   ph_n = PH_HOLD_HIGH;
    if (go_down) ph_n = PH_HOLD_LOW;
  end

  assign hold_load = go_up | go_down;
  assign hold_val  = go_up ? CW'(RISE_HOLD) : CW'(FALL_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph         <= PH_WAIT_RISE;
      rise_pulse <= 1'b0;
      fall_pulse <= 1'b0;
    end else begin
      ph         <= ph_n;
      rise_pulse <= go_up;
      fall_pulse <= go_down;
    end
  end

  assign level_out = ph[0];

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rise_pulse && fall_pulse));
  // R7
  rise_match_chk: assert property (@(posedge clk) disable iff (rst)
    rise_pulse |-> (level_out && !$past(level_out)));
  // R7
  fall_match_chk: assert property (@(posedge clk) disable iff (rst)
    fall_pulse |-> (!level_out && $past(level_out)));
  // R7
  change_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (level_out != $past(level_out)) |-> (rise_pulse || fall_pulse));
  // R3
  hold_timer_chk: assert property (@(posedge clk) disable iff (rst)
    phase_is_hold(ph) == hold_busy);
  // R8
  order_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_WAIT_RISE) |=> (ph == PH_WAIT_RISE || ph == PH_HOLD_HIGH));
  // R8
  order_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_WAIT_FALL) |=> (ph == PH_WAIT_FALL || ph == PH_HOLD_LOW));
  // R5
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_is_hold(ph) && !hold_last) |=> (ph == $past(ph)));
endmodule

// File: tb/tb_lockout_debouncer.sv
module tb_lockout_debouncer;
  localparam int RH = 4;
  localparam int FH = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic level_out, rise_pulse, fall_pulse;

  always #5 clk = ~clk;

  lockout_debouncer #(.RISE_HOLD(RH), .FALL_HOLD(FH), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .noisy_in(din),
    .level_out(level_out), .rise_pulse(rise_pulse), .fall_pulse(fall_pulse));

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  model_on = 1'b0;
  bit  done = 1'b0;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Requirement model: 2 flop sync + 1 history flop, then phase arithmetic.
  logic d0, d1, d2, mlev, mrise, mfall;
  int   mleft;
  always @(posedge clk) begin
    if (rst) begin
      d0 <= 0; d1 <= 0; d2 <= 0;
      mlev <= 0; mrise <= 0; mfall <= 0; mleft <= 0;
    end else begin
      automatic logic up;
      automatic logic dn;
      up = 1'b0;
      dn = 1'b0;
      if (mleft == 0) begin
        if (!mlev && d1 && !d2)      up = 1'b1;
        else if (mlev && !d1 && d2)  dn = 1'b1;
      end else if (mleft == 1 && d1 != mlev) begin
        up = d1;
        dn = !d1;
      end
      mrise <= up;
      mfall <= dn;
      if (up)             begin mlev <= 1'b1; mleft <= RH; end
      else if (dn)        begin mlev <= 1'b0; mleft <= FH; end
      else if (mleft > 0) mleft <= mleft - 1;
      d0 <= din; d1 <= d0; d2 <= d1;
    end
  end

  always @(negedge clk) begin
    if (model_on && !done) begin
      chk("R2 R3 R4 R5 R6 level model", level_out, mlev);
      chk("R7 rise strobe model", rise_pulse, mrise);
      chk("R7 fall strobe model", fall_pulse, mfall);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    // R1: outputs during reset
    chk("R1 reset level", level_out, 1'b0);
    chk("R1 reset rise", rise_pulse, 1'b0);
    chk("R1 reset fall", fall_pulse, 1'b0);
    rst = 1'b0;
    model_on = 1'b1;
    step(5);

    // R2: rise seen on the third edge
    din = 1'b1;
    step(2);
    chk("R2 level before latency", level_out, 1'b0);
    step(1);
    chk("R2 level after latency", level_out, 1'b1);
    chk("R7 rise strobe on change", rise_pulse, 1'b1);
    // R6: input drops during the high holdoff, seen at its end
    din = 1'b0;
    step(1);
    chk("R7 rise strobe one cycle", rise_pulse, 1'b0);
    step(2);
    chk("R3 held high in holdoff", level_out, 1'b1);
    step(1);
    chk("R6 hidden fall at holdoff end", level_out, 1'b0);
    chk("R6 fall strobe at holdoff end", fall_pulse, 1'b1);
    // R5: bounces in the low holdoff, then settle high
    din = 1'b1; step(1);
    din = 1'b0; step(1);
    din = 1'b1;
    step(3);
    chk("R5 held low, not retriggered", level_out, 1'b0);
    step(1);
    chk("R5 holdoff ends on time", level_out, 1'b1);
    chk("R5 rise strobe at end", rise_pulse, 1'b1);
    // R4: clean fall from the wait-for-fall phase
    step(8);
    din = 1'b0;
    step(2);
    chk("R4 level before latency", level_out, 1'b1);
    step(1);
    chk("R4 level after latency", level_out, 1'b0);
    chk("R4 fall strobe", fall_pulse, 1'b1);
    // R1: reset while output high
    step(FH + 2);
    din = 1'b1;
    step(3);
    chk("R1 precondition high", level_out, 1'b1);
    rst = 1'b1;
    step(1);
    chk("R1 mid-run reset level", level_out, 1'b0);
    chk("R1 mid-run reset rise", rise_pulse, 1'b0);
    din = 1'b0;
    step(2);
    rst = 1'b0;
    step(4);

    // R3 R5 R6 R7 R8: every 10-bit pattern, one bit per clock
    for (int p = 0; p < 1024; p++) begin
      for (int b = 0; b < 10; b++) begin
        din = p[b];
        @(negedge clk);
      end
      repeat (12) @(negedge clk);
    end
    din = 1'b0;
    step(20);
    finish_run();
  end
endmodule